// File: doc/BRIEF.md
# Critical Load Fetch Halt Controller

This block decides when instruction fetch should stop because a load that matters is waiting on main memory. Software profiling marks some loads as promising and gives each a miss stride, which is the expected number of accesses between two misses. The block watches every load access. For each marked load it keeps a hardware count of the accesses made since that load last missed. When a marked load misses in the last-level cache, the block compares the count with the stride the access carries. If the two are equal, the miss is critical. Fetch is then held off until main memory returns the fill for that miss.

Up to eight loads are tracked at once, in a small table searched by load ID. A new load takes the slot named by a round-robin pointer. Only one halt is outstanding at a time, and it ends only on the fill whose tag was captured when the halt began. A pipeline flush cancels the halt at once and leaves all tracked counts as they were. The caches, the fill path and any miss oracle sit outside this block.

Top module: `fetch_halt_ctrl`

## Requirements
- R1: After reset, `fetch_halt` is 0 and no load is tracked. The first marked access to a load ID only allocates an entry with count 0 and never raises `fetch_halt`, even if it misses.
- R2: An access with `acc_flag`=0 is ignored. It allocates nothing, changes no count and never raises `fetch_halt`.
- R3: A marked access that hits a tracked entry, has `acc_miss`=1 and whose entry count equals `acc_stride` is critical. When no halt is active, `fetch_halt` is 1 after the next clock edge. A stride of 0 means two misses in a row.
- R4: A marked miss whose count differs from `acc_stride` does not halt. Every marked miss on a tracked entry resets its count to 0, whether or not it is critical.
- R5: A marked access with `acc_miss`=0 on a tracked entry adds 1 to its count. The count saturates at 2^CNT_W-1.
- R6: While halted, `fetch_halt` stays 1 through fills whose `fill_tag` differs from the captured tag.
- R7: A fill whose `fill_tag` equals the captured tag clears `fetch_halt` at the next clock edge.
- R8: A critical miss that arrives during an active halt neither extends the halt nor replaces the captured tag. A fill carrying the newer miss's tag does not end the halt.
- R9: `flush` clears `fetch_halt` at the next edge, and this takes priority over a critical miss in the same cycle. Tracked counts are kept.
- R10: The table holds 8 entries (ENTRIES). When the table is full, a new load replaces slots in round-robin order starting from slot 0, so the ninth distinct load evicts the first one allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A load access is presented this cycle |
| acc_flag | input | 1 | Software marked this load as promising |
| acc_id | input | ID_W | Load identifier |
| acc_stride | input | CNT_W | Annotated miss stride for this load |
| acc_miss | input | 1 | The access missed to main memory |
| acc_tag | input | TAG_W | Tag of the outstanding miss |
| fill_valid | input | 1 | A memory fill returns this cycle |
| fill_tag | input | TAG_W | Tag of the returning fill |
| flush | input | 1 | Pipeline flush |
| fetch_halt | output | 1 | Registered fetch stall request |

## Verification
The main sequence has one load advance its count with marked hits while unmarked accesses to the same ID are interleaved. A later stride match shows whether those unmarked accesses wrongly moved the count. Strides of 0, 1, 2 and the saturated maximum separate the real count from an off-by-one or a count that wraps. Wrong-tag fills, a second critical miss and the fill for that second miss, all sent during a halt, separate release by the captured tag from release by any fill or by the newest miss. Flushes show that the halt is cancelled while the counts survive. A full table followed by a ninth load shows the round-robin victim.

// File: rtl/fhc_pkg.sv
package fhc_pkg;
  typedef enum logic {
    HALT_IDLE = 1'b0,
    HALT_WAIT = 1'b1
  } halt_state_e;
endpackage

// File: rtl/fhc_miss_table.sv
module fhc_miss_table #(
  parameter int ENTRIES = 8,
  parameter int ID_W    = 4,
  parameter int CNT_W   = 3,
  parameter int TAG_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_flag,
  input  logic [ID_W-1:0]  acc_id,
  input  logic [CNT_W-1:0] acc_stride,
  input  logic             acc_miss,
  input  logic [TAG_W-1:0] acc_tag,
  output logic             crit,
  output logic [TAG_W-1:0] crit_tag
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(ENTRIES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ENTRIES-1:0] ent_valid;
  logic [ID_W-1:0]    ent_id  [ENTRIES];
  logic [CNT_W-1:0]   ent_cnt [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [PTR_W-1:0]   rr_ptr;
  logic [CNT_W-1:0]   hit_cnt;
  logic               track, any_hit, alloc;

  assign track   = acc_valid && acc_flag;
  assign any_hit = |hit_vec;
  assign alloc   = track && !any_hit;

  always_comb begin
    hit_cnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_cnt = hit_cnt | ent_cnt[i];
    end
  end

  assign crit     = track && any_hit && acc_miss && (hit_cnt == acc_stride);
  assign crit_tag = acc_tag;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign hit_vec[g] = ent_valid[g] && (ent_id[g] == acc_id);

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[g] <= 1'b0;
        ent_id[g]    <= '0;
        ent_cnt[g]   <= '0;
      end else if (track && hit_vec[g]) begin
        if (acc_miss)                  ent_cnt[g] <= '0;
        else if (ent_cnt[g] != CNT_MAX) ent_cnt[g] <= ent_cnt[g] + 1'b1;
      end else if (alloc && (rr_ptr == PTR_W'(g))) begin
        ent_valid[g] <= 1'b1;
        ent_id[g]    <= acc_id;
        ent_cnt[g]   <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rr_ptr <= '0;
    else if (alloc) rr_ptr <= (rr_ptr == LAST_SLOT) ? '0 : rr_ptr + 1'b1;
  end

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R10
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    rr_ptr <= LAST_SLOT); // R10
  AST_NO_CRIT_UNMARKED: assert property (@(posedge clk) disable iff (rst)
    !acc_flag |-> !crit); // R2
endmodule

// File: rtl/fhc_halt_fsm.sv
module fhc_halt_fsm #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             crit,
  input  logic [TAG_W-1:0] crit_tag,
  input  logic             fill_valid,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             flush,
  output logic             halt
);
  import fhc_pkg::*;

  halt_state_e      state;
  logic [TAG_W-1:0] tag_q;
  logic             release_hit;

  assign release_hit = fill_valid && (fill_tag == tag_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= HALT_IDLE;
      tag_q <= '0;
    end else if (flush) begin
      state <= HALT_IDLE;
    end else begin
      case (state)
        HALT_IDLE: if (crit) begin
          state <= HALT_WAIT;
          tag_q <= crit_tag;
        end
        HALT_WAIT: if (release_hit) state <= HALT_IDLE;
        default:   state <= HALT_IDLE;
      endcase
    end
  end

  assign halt = (state == HALT_WAIT);

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> !halt); // R9
  AST_FILL_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (halt && release_hit) |=> !halt); // R7
  AST_HOLD_HALT: assert property (@(posedge clk) disable iff (rst)
    (halt && !release_hit && !flush) |=> halt); // R6
  AST_TAG_KEPT: assert property (@(posedge clk) disable iff (rst)
    halt |=> (!halt || $stable(tag_q))); // R8
  AST_SET_ON_CRIT: assert property (@(posedge clk) disable iff (rst)
    (!halt && crit && !flush) |=> (halt && tag_q == $past(crit_tag))); // R3
endmodule

// File: rtl/fetch_halt_ctrl.sv
module fetch_halt_ctrl #(
  parameter int ENTRIES = 8,
  parameter int ID_W    = 4,
  parameter int CNT_W   = 3,
  parameter int TAG_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_flag,
  input  logic [ID_W-1:0]  acc_id,
  input  logic [CNT_W-1:0] acc_stride,
  input  logic             acc_miss,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic             fill_valid,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             flush,
  output logic             fetch_halt
);
  logic             crit;
  logic [TAG_W-1:0] crit_tag;

  fhc_miss_table #(
    .ENTRIES(ENTRIES), .ID_W(ID_W), .CNT_W(CNT_W), .TAG_W(TAG_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_flag(acc_flag), .acc_id(acc_id),
    .acc_stride(acc_stride), .acc_miss(acc_miss), .acc_tag(acc_tag),
    .crit(crit), .crit_tag(crit_tag)
  );

  fhc_halt_fsm #(.TAG_W(TAG_W)) u_fsm (
    .clk(clk), .rst(rst),
    .crit(crit), .crit_tag(crit_tag),
    .fill_valid(fill_valid), .fill_tag(fill_tag),
    .flush(flush), .halt(fetch_halt)
  );

  AST_QUIET_NO_MISS: assert property (@(posedge clk) disable iff (rst)
    (!fetch_halt && !(acc_valid && acc_flag && acc_miss)) |=> !fetch_halt); // R2
endmodule

// File: tb/fetch_halt_ctrl_test.sv
module fetch_halt_ctrl_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       av;
    logic       fl;
    logic [3:0] id;
    logic [2:0] st;
    logic       ms;
    logic [3:0] tg;
    logic       fv;
    logic [3:0] ft;
    logic       fx;
    logic       eh;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 22;
  // av fl id st ms tg fv ft fx eh rq
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,4'd1,3'd0,1'b1,4'd1,1'b0,4'd0,1'b0,1'b0,4'd1}, // R1 alloc miss
    '{1'b1,1'b1,4'd1,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,4'd5}, // R5 cnt 1
    '{1'b1,1'b0,4'd1,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,4'd2}, // R2 unmarked hit
    '{1'b1,1'b0,4'd1,3'd1,1'b1,4'd2,1'b0,4'd0,1'b0,1'b0,4'd2}, // R2 unmarked miss
    '{1'b1,1'b1,4'd1,3'd2,1'b1,4'd3,1'b0,4'd0,1'b0,1'b0,4'd4}, // R4 1 vs 2
    '{1'b1,1'b1,4'd1,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,4'd5}, // R5 cnt 1
    '{1'b1,1'b1,4'd1,3'd1,1'b1,4'd5,1'b0,4'd0,1'b0,1'b1,4'd3}, // R3 critical
    '{1'b0,1'b0,4'd0,3'd0,1'b0,4'd0,1'b1,4'd3,1'b0,1'b1,4'd6}, // R6 wrong tag
    '{1'b1,1'b1,4'd1,3'd0,1'b1,4'd6,1'b0,4'd0,1'b0,1'b1,4'd8}, // R8 second crit
    '{1'b0,1'b0,4'd0,3'd0,1'b0,4'd0,1'b1,4'd6,1'b0,1'b1,4'd8}, // R8 newer tag
    '{1'b0,1'b0,4'd0,3'd0,1'b0,4'd0,1'b1,4'd5,1'b0,1'b0,4'd7}, // R7 release
    '{1'b0,1'b0,4'd0,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,4'd7}, // R7 stays low
    '{1'b1,1'b1,4'd2,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,4'd1}, // R1 alloc id2
    '{1'b1,1'b1,4'd2,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,4'd5}, // R5 cnt 1
    '{1'b1,1'b1,4'd2,3'd1,1'b1,4'd7,1'b0,4'd0,1'b0,1'b1,4'd3}, // R3 critical
    '{1'b1,1'b1,4'd2,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b1,4'd6}, // R6 cnt 1, hold
    '{1'b0,1'b0,4'd0,3'd0,1'b0,4'd0,1'b0,4'd0,1'b1,1'b0,4'd9}, // R9 flush
    '{1'b1,1'b1,4'd2,3'd1,1'b1,4'd8,1'b0,4'd0,1'b0,1'b1,4'd9}, // R9 count kept
    '{1'b0,1'b0,4'd0,3'd0,1'b0,4'd0,1'b1,4'd8,1'b0,1'b0,4'd7}, // R7 release
    '{1'b1,1'b1,4'd2,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0,1'b0,4'd5}, // R5 cnt 1
    '{1'b1,1'b1,4'd2,3'd1,1'b1,4'd9,1'b0,4'd0,1'b1,1'b0,4'd9}, // R9 flush wins
    '{1'b1,1'b1,4'd2,3'd1,1'b1,4'd10,1'b0,4'd0,1'b0,1'b0,4'd4} // R4 count reset
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0, acc_flag = 1'b0, acc_miss = 1'b0;
  logic [3:0] acc_id = '0, acc_tag = '0, fill_tag = '0;
  logic [2:0] acc_stride = '0;
  logic       fill_valid = 1'b0, flush = 1'b0;
  logic       fetch_halt;
  int         n_checks = 0, n_errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_halt_ctrl uut (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_flag(acc_flag), .acc_id(acc_id),
    .acc_stride(acc_stride), .acc_miss(acc_miss), .acc_tag(acc_tag),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .flush(flush),
    .fetch_halt(fetch_halt)
  );

  task automatic check(input logic exp, input string req);
    n_checks++;
    if (fetch_halt !== exp) begin
      n_errors++;
      $display("FAIL %s: fetch_halt=%b expected %b", req, fetch_halt, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge after one posedge
  task automatic step(input logic av, input logic fl, input logic [3:0] id,
                      input logic [2:0] st, input logic ms, input logic [3:0] tg,
                      input logic fv, input logic [3:0] ft, input logic fx);
    acc_valid = av; acc_flag = fl; acc_id = id; acc_stride = st;
    acc_miss = ms; acc_tag = tg; fill_valid = fv; fill_tag = ft; flush = fx;
    @(negedge clk);
    acc_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    check(1'b0, "R1 reset state");

    for (int k = 0; k < NV; k++) begin
      step(VEC[k].av, VEC[k].fl, VEC[k].id, VEC[k].st, VEC[k].ms, VEC[k].tg,
           VEC[k].fv, VEC[k].ft, VEC[k].fx);
      check(VEC[k].eh, $sformatf("R%0d vector %0d", VEC[k].rq, k));
    end

    // R1: reset during a halt clears it and empties the table
    step(1'b1,1'b1,4'd3,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0);
    step(1'b1,1'b1,4'd3,3'd0,1'b1,4'd11,1'b0,4'd0,1'b0);
    check(1'b1, "R3 halt before reset");
    do_reset();
    check(1'b0, "R1 reset clears halt");
    step(1'b1,1'b1,4'd3,3'd0,1'b1,4'd12,1'b0,4'd0,1'b0);
    check(1'b0, "R1 table empty after reset");

    // R5: saturation at 7 (id 4)
    do_reset();
    step(1'b1,1'b1,4'd4,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0);
    for (int k = 0; k < 9; k++) step(1'b1,1'b1,4'd4,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0);
    step(1'b1,1'b1,4'd4,3'd7,1'b1,4'd13,1'b0,4'd0,1'b0);
    check(1'b1, "R5 saturated count matches stride 7");
    step(1'b0,1'b0,4'd0,3'd0,1'b0,4'd0,1'b1,4'd13,1'b0);
    check(1'b0, "R7 release after saturation test");

    // R10: eight entries coexist, ninth evicts slot 0
    do_reset();
    for (int k = 0; k < 8; k++)
      step(1'b1,1'b1,4'(k),3'd0,1'b0,4'd0,1'b0,4'd0,1'b0);
    step(1'b1,1'b1,4'd0,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0);
    step(1'b1,1'b1,4'd0,3'd1,1'b1,4'd14,1'b0,4'd0,1'b0);
    check(1'b1, "R10 id0 still tracked with full table");
    step(1'b0,1'b0,4'd0,3'd0,1'b0,4'd0,1'b1,4'd14,1'b0);
    check(1'b0, "R7 release in R10 test");
    step(1'b1,1'b1,4'd0,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0);
    step(1'b1,1'b1,4'd8,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0);
    step(1'b1,1'b1,4'd0,3'd0,1'b0,4'd0,1'b0,4'd0,1'b0);
    step(1'b1,1'b1,4'd0,3'd0,1'b1,4'd15,1'b0,4'd0,1'b0);
    check(1'b1, "R10 ninth load evicted id0, reallocated with count 0");
    step(1'b0,1'b0,4'd0,3'd0,1'b0,4'd0,1'b1,4'd15,1'b0);
    check(1'b0, "R7 final release");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule